// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block is the digital start-up controller of a buck regulator whose output voltage follows a reference DAC code. It takes three enable-qualifying flags, already synchronized: bias supply power-on-reset good, driver supply power-on-reset good, and the output of the enable comparator. While any of them is low, the PWM outputs stay tri-stated, the reference code stays at zero and power-good stays low.

Once all three are present, and no "no load" code is presented in 5-bit mode, the sequencer waits a fixed delay. It then ramps the reference code one LSB at a time. In the two-stage modes the first ramp stops at a fixed boot code. The code is held there for a fixed period, and then the VID input is sampled. A second ramp moves the code, up or down, to the sampled value. The single-stage modes skip the boot stage and ramp from zero straight to the sampled value. Power-good follows the external in-window flag once the final ramp has finished. The VID input is the already-decoded target code.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and in every cycle in shutdown, `pwm_hiz`=1, `dac_code`=0 and `pgood`=0.
- R2: Shutdown is left only when `bias_por_ok`, `drv_por_ok` and `en_cmp_ok` are all 1 at a clock edge. `pwm_hiz` falls in the cycle after that edge.
- R3: With `mode_sel`=2'b11 (5-bit single-stage mode), `vid_code[4:0]`=5'b11111 keeps the block in shutdown. The same code does not block start-up in any other mode.
- R4: After shutdown is left, `dac_code` stays 0 for TD1_CYC cycles plus RAMP_DIV cycles. It becomes 1 on the next edge.
- R5: In the two-stage modes (`mode_sel`=2'b00 or 2'b01), the code rises by one every RAMP_DIV cycles up to BOOT_CODE. It is then held for TD3_CYC cycles.
- R6: When the hold ends with `vid_valid`=1, the code moves one step every RAMP_DIV cycles toward `vid_code`, upward or downward. It then stays at `vid_code`.
- R7: `pgood` is 1 in the cycle after an edge at which the final ramp has finished, `out_in_window`=1 and all enable flags are 1. Otherwise it is 0.
- R8: In the cycle after any edge at which an enable flag is 0, the block is back in shutdown: `pwm_hiz`=1, `dac_code`=0 and `pgood`=0.
- R9: If `vid_valid`=0 when the hold ends, the code stays at BOOT_CODE. `vid_code` is re-sampled on every edge until `vid_valid`=1.
- R10: In the single-stage modes (`mode_sel`=2'b10 or 2'b11), the VID is sampled at the end of the delay. The code ramps from 0 straight to `vid_code`, with no boot level.
- R11: Apart from the jump back to 0, `dac_code` never changes by more than one between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_por_ok | input | 1 | Bias supply power-on-reset good |
| drv_por_ok | input | 1 | Driver supply power-on-reset good |
| en_cmp_ok | input | 1 | Enable comparator output |
| mode_sel | input | 2 | 00/01 two-stage, 10 single-stage 6-bit, 11 single-stage 5-bit |
| vid_code | input | CODE_W | Decoded VID target code; bits [4:0] hold the raw code in 5-bit mode |
| vid_valid | input | 1 | VID code is valid |
| out_in_window | input | 1 | Output voltage is inside its regulation window |
| dac_code | output | CODE_W | Reference DAC code |
| pwm_hiz | output | 1 | 1 = tri-state the PWM outputs |
| pgood | output | 1 | Power-good |

## Verification
The sequence is driven in several ways:
- Partial enable sets show that start-up needs all three flags.
- Targets above and below the boot code show that the second ramp moves in both directions.
- A withheld VID-valid flag shows that the block waits at the boot level.
- Switching between the 5-bit mode and another single-stage mode with the all-ones code shows that only the 5-bit mode blocks start-up.
- Dropping an enable in mid-ramp shows the immediate return to shutdown.

At a fixed cycle after start-up, a two-stage run still sits at the boot code while a single-stage run has already passed it, which shows that the boot stage is skipped.

// File: rtl/vrss_pkg.sv
package vrss_pkg;

    typedef enum logic [2:0] {
        ST_SHUT      = 3'd0,
        ST_DELAY     = 3'd1,
        ST_RAMP_BOOT = 3'd2,
        ST_HOLD      = 3'd3,
        ST_WAIT_VID  = 3'd4,
        ST_RAMP_VID  = 3'd5,
        ST_DONE      = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_TWO_A   = 2'b00,
        MODE_TWO_B   = 2'b01,
        MODE_ONE_6B  = 2'b10,
        MODE_ONE_5B  = 2'b11
    } seq_mode_e;

    localparam int NOLOAD_W = 5;

    typedef struct packed {
        logic bias_ok;
        logic drv_ok;
        logic cmp_ok;
    } en_flags_t;

    function automatic logic mode_two_stage(input logic [1:0] m);
        return (m == MODE_TWO_A) || (m == MODE_TWO_B);
    endfunction

    function automatic logic code_no_load(input logic [1:0] m,
                                          input logic [NOLOAD_W-1:0] v);
        return (m == MODE_ONE_5B) && (&v);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vrss_gate.sv
module vrss_gate
    import vrss_pkg::*;
(
    input  en_flags_t             flags,
    input  logic [1:0]            mode_sel,
    input  logic [NOLOAD_W-1:0]   vid_lo,
    output logic                  en_all,
    output logic                  start_ok,
    output logic                  two_stage
);

    always_comb begin
        en_all    = flags.bias_ok & flags.drv_ok & flags.cmp_ok;
        start_ok  = en_all & ~code_no_load(mode_sel, vid_lo);
        two_stage = mode_two_stage(mode_sel);
    end

endmodule

// File: rtl/vrss_ramp.sv
module vrss_ramp #(
    parameter int CODE_W   = 8,
    parameter int RAMP_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic [CODE_W-1:0] tgt,
    output logic [CODE_W-1:0] code,
    output logic              at_tgt
);

    localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);

    logic [CODE_W-1:0] code_q;
    logic [DIV_W-1:0]  div_q;
    logic              step_now;
    logic              go_up;

    assign at_tgt   = (code_q == tgt);
    assign step_now = run && !at_tgt && (div_q == DIV_LAST);
    assign go_up    = (tgt > code_q);
    assign code     = code_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q <= '0;
            div_q  <= '0;
        end else if (run && !at_tgt) begin
            if (step_now) begin
                div_q  <= '0;
                code_q <= go_up ? code_q + 1'b1 : code_q - 1'b1;
            end else begin
                div_q  <= div_q + 1'b1;
            end
        end else begin
            div_q <= '0;
        end
    end

endmodule

// File: rtl/vrss_fsm.sv
module vrss_fsm
    import vrss_pkg::*;
#(
    parameter int                CODE_W    = 8,
    parameter int                TD1_CYC   = 16,
    parameter int                TD3_CYC   = 32,
    parameter logic [CODE_W-1:0] BOOT_CODE = 8'd44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_all,
    input  logic              start_ok,
    input  logic              two_stage,
    input  logic [CODE_W-1:0] vid_code,
    input  logic              vid_valid,
    input  logic              at_tgt,
    output seq_state_e        state,
    output logic [CODE_W-1:0] tgt
);

    localparam int TMR_MAX = max_int(TD1_CYC, TD3_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] TD1_LAST = TMR_W'(TD1_CYC - 1);
    localparam logic [TMR_W-1:0] TD3_LAST = TMR_W'(TD3_CYC - 1);

    seq_state_e        st_q, st_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic [CODE_W-1:0] tgt_q, tgt_d;

    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        tgt_d = tgt_q;
        if (!en_all) begin
            st_d  = ST_SHUT;
            tmr_d = '0;
        end else begin
            unique case (st_q)
                ST_SHUT: begin
                    if (start_ok) begin
                        st_d  = ST_DELAY;
                        tmr_d = '0;
                    end
                end
                ST_DELAY: begin
                    if (tmr_q == TD1_LAST) begin
                        tmr_d = '0;
                        if (two_stage) begin
                            tgt_d = BOOT_CODE;
                            st_d  = ST_RAMP_BOOT;
                        end else if (vid_valid) begin
                            tgt_d = vid_code;
                            st_d  = ST_RAMP_VID;
                        end else begin
                            st_d  = ST_WAIT_VID;
                        end
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                ST_RAMP_BOOT: begin
                    if (at_tgt) begin
                        st_d  = ST_HOLD;
                        tmr_d = '0;
                    end
                end
                ST_HOLD: begin
                    if (tmr_q == TD3_LAST) begin
                        tmr_d = '0;
                        if (vid_valid) begin
                            tgt_d = vid_code;
                            st_d  = ST_RAMP_VID;
                        end else begin
                            st_d  = ST_WAIT_VID;
                        end
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                ST_WAIT_VID: begin
                    if (vid_valid) begin
                        tgt_d = vid_code;
                        st_d  = ST_RAMP_VID;
                    end
                end
                ST_RAMP_VID: begin
                    if (at_tgt) begin
                        st_d = ST_DONE;
                    end
                end
                ST_DONE: begin
                    st_d = ST_DONE;
                end
                default: begin
                    st_d = ST_SHUT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_SHUT;
            tmr_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
            tgt_q <= tgt_d;
        end
    end

    assign state = st_q;
    assign tgt   = tgt_q;

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vrss_pkg::*;
#(
    parameter int                CODE_W    = 8,
    parameter int                TD1_CYC   = 16,
    parameter int                TD3_CYC   = 32,
    parameter int                RAMP_DIV  = 4,
    parameter logic [CODE_W-1:0] BOOT_CODE = 8'd44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bias_por_ok,
    input  logic              drv_por_ok,
    input  logic              en_cmp_ok,
    input  logic [1:0]        mode_sel,
    input  logic [CODE_W-1:0] vid_code,
    input  logic              vid_valid,
    input  logic              out_in_window,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwm_hiz,
    output logic              pgood
);

    en_flags_t         flags;
    logic              en_all;
    logic              start_ok;
    logic              two_stage;
    logic              at_tgt;
    logic              ramp_run;
    seq_state_e        state;
    logic [CODE_W-1:0] tgt;
    logic              pgood_q;

    assign flags = '{bias_ok: bias_por_ok, drv_ok: drv_por_ok, cmp_ok: en_cmp_ok};

    vrss_gate u_gate (
        .flags     (flags),
        .mode_sel  (mode_sel),
        .vid_lo    (vid_code[NOLOAD_W-1:0]),
        .en_all    (en_all),
        .start_ok  (start_ok),
        .two_stage (two_stage)
    );

    vrss_fsm #(
        .CODE_W    (CODE_W),
        .TD1_CYC   (TD1_CYC),
        .TD3_CYC   (TD3_CYC),
        .BOOT_CODE (BOOT_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_all    (en_all),
        .start_ok  (start_ok),
        .two_stage (two_stage),
        .vid_code  (vid_code),
        .vid_valid (vid_valid),
        .at_tgt    (at_tgt),
        .state     (state),
        .tgt       (tgt)
    );

    assign ramp_run = (state == ST_RAMP_BOOT) || (state == ST_RAMP_VID);

    vrss_ramp #(
        .CODE_W   (CODE_W),
        .RAMP_DIV (RAMP_DIV)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .clr    (!en_all),
        .run    (ramp_run),
        .tgt    (tgt),
        .code   (dac_code),
        .at_tgt (at_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pgood_q <= 1'b0;
        end else begin
            pgood_q <= en_all && (state == ST_DONE) && out_in_window;
        end
    end

    assign pgood   = pgood_q;
    assign pwm_hiz = (state == ST_SHUT);

endmodule

// File: rtl/vrss_chk.sv
module vrss_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bias_por_ok,
    input logic              drv_por_ok,
    input logic              en_cmp_ok,
    input logic [1:0]        mode_sel,
    input logic [4:0]        vid_lo,
    input logic              out_in_window,
    input logic [CODE_W-1:0] dac_code,
    input logic              pwm_hiz,
    input logic              pgood
);

    logic all_en;
    assign all_en = bias_por_ok && drv_por_ok && en_cmp_ok;

    AST_SHUT_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        pwm_hiz |-> (dac_code == '0 && !pgood)); // R1

    AST_START_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        (pwm_hiz && !all_en) |=> pwm_hiz); // R2

    AST_NOLOAD_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (pwm_hiz && mode_sel == 2'b11 && (&vid_lo)) |=> pwm_hiz); // R3

    AST_PGOOD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pgood |-> (!pwm_hiz && $past(out_in_window))); // R7

    AST_LOSS_TO_SHUT: assert property (@(posedge clk) disable iff (rst)
        !all_en |=> (pwm_hiz && dac_code == '0 && !pgood)); // R8

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (dac_code != $past(dac_code)) |->
            (dac_code == '0 || dac_code == $past(dac_code) + 1'b1
                            || dac_code == $past(dac_code) - 1'b1)); // R11

endmodule

bind vr_softstart_seq vrss_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bias_por_ok   (bias_por_ok),
    .drv_por_ok    (drv_por_ok),
    .en_cmp_ok     (en_cmp_ok),
    .mode_sel      (mode_sel),
    .vid_lo        (vid_code[4:0]),
    .out_in_window (out_in_window),
    .dac_code      (dac_code),
    .pwm_hiz       (pwm_hiz),
    .pgood         (pgood)
);

// File: tb/vr_softstart_seq_test.sv
`timescale 1ns/1ps
module vr_softstart_seq_test;

    localparam int CW   = 8;
    localparam int TD1  = 5;
    localparam int TD3  = 8;
    localparam int DIV  = 3;
    localparam int BOOT = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bias = 1'b0, drv = 1'b0, encmp = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] vid = '0;
    logic          vvalid = 1'b0;
    logic          win = 1'b0;
    logic [CW-1:0] dac_code;
    logic          pwm_hiz, pgood;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vr_softstart_seq #(
        .CODE_W(CW), .TD1_CYC(TD1), .TD3_CYC(TD3),
        .RAMP_DIV(DIV), .BOOT_CODE(8'(BOOT))
    ) uut (
        .clk(clk), .rst(rst), .bias_por_ok(bias), .drv_por_ok(drv),
        .en_cmp_ok(encmp), .mode_sel(mode), .vid_code(vid),
        .vid_valid(vvalid), .out_in_window(win),
        .dac_code(dac_code), .pwm_hiz(pwm_hiz), .pgood(pgood)
    );

    // Behavioural reference: phase 0 shut, 1 delay, 2 boot ramp, 3 hold,
    // 4 waiting for VID, 5 target ramp, 6 finished.
    int m_ph = 0, m_cnt = 0, m_div = 0, m_code = 0, m_tgt = 0;
    bit m_pg = 1'b0;

    task automatic m_take_vid();
        if (vvalid) begin
            m_tgt = int'(vid);
            m_ph  = 5;
        end else begin
            m_ph = 4;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_div = 0; m_code = 0; m_tgt = 0; m_pg = 0;
        end else if (!(bias && drv && encmp)) begin
            m_ph = 0; m_cnt = 0; m_div = 0; m_code = 0; m_pg = 0;
        end else begin
            m_pg = (m_ph == 6) && win;
            case (m_ph)
                0: if (!(mode == 2'b11 && vid[4:0] == 5'h1F)) begin
                       m_ph = 1; m_cnt = 0;
                   end
                1: if (m_cnt == TD1 - 1) begin
                       m_cnt = 0;
                       if (mode[1] == 1'b0) begin m_tgt = BOOT; m_ph = 2; end
                       else m_take_vid();
                   end else m_cnt++;
                2, 5: if (m_code == m_tgt) begin
                       m_div = 0; m_cnt = 0;
                       m_ph = (m_ph == 2) ? 3 : 6;
                   end else if (m_div == DIV - 1) begin
                       m_div = 0;
                       m_code = (m_tgt > m_code) ? m_code + 1 : m_code - 1;
                   end else m_div++;
                3: if (m_cnt == TD3 - 1) begin
                       m_cnt = 0; m_take_vid();
                   end else m_cnt++;
                4: m_take_vid();
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string ph_tag(input int ph);
        case (ph)
            0: return "R1";
            1: return "R4";
            2: return "R5";
            3, 4: return "R9";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Compare against the reference every cycle, away from the active edge.
    int prev_code = 0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(int'(dac_code) == m_code, ph_tag(m_ph), int'(dac_code), m_code);
            chk(pwm_hiz == (m_ph == 0), ph_tag(m_ph), int'(pwm_hiz), int'(m_ph == 0));
            chk(pgood == m_pg, "R7", int'(pgood), int'(m_pg));
            if (int'(dac_code) != prev_code && dac_code != '0) begin
                chk((int'(dac_code) - prev_code == 1) || (prev_code - int'(dac_code) == 1),
                    "R11", int'(dac_code), prev_code);
            end
            prev_code = int'(dac_code);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(pwm_hiz == 1'b1, "R1", int'(pwm_hiz), 1);
        chk(dac_code == '0, "R1", int'(dac_code), 0);
        chk(pgood == 1'b0, "R1", int'(pgood), 0);

        // R2: partial enable sets must not start.
        mode = 2'b00; vid = 8'd60; vvalid = 1'b1; win = 1'b1;
        bias = 1'b1; drv = 1'b1; encmp = 1'b0;
        cyc(20);
        chk(pwm_hiz == 1'b1, "R2", int'(pwm_hiz), 1);
        drv = 1'b0; encmp = 1'b1;
        cyc(20);
        chk(pwm_hiz == 1'b1, "R2", int'(pwm_hiz), 1);
        drv = 1'b1;
        cyc(1);
        chk(pwm_hiz == 1'b0, "R2", int'(pwm_hiz), 0);
        cyc(TD1 + DIV - 1);
        chk(dac_code == 8'd0, "R4", int'(dac_code), 0);
        cyc(1);
        chk(dac_code == 8'd1, "R4", int'(dac_code), 1);
        cyc(DIV * (BOOT - 1) + 1);
        chk(dac_code == 8'(BOOT), "R5", int'(dac_code), BOOT);
        cyc(TD3 - 1);
        chk(dac_code == 8'(BOOT), "R5", int'(dac_code), BOOT);
        cyc(300);
        chk(dac_code == 8'd60, "R6", int'(dac_code), 60);
        chk(pgood == 1'b1, "R7", int'(pgood), 1);
        win = 1'b0;
        cyc(1);
        chk(pgood == 1'b0, "R7", int'(pgood), 0);
        win = 1'b1;
        cyc(1);
        chk(pgood == 1'b1, "R7", int'(pgood), 1);

        // R8: loss of an enable, once finished and again in mid-ramp.
        encmp = 1'b0;
        cyc(1);
        chk(pwm_hiz == 1'b1 && dac_code == '0 && !pgood, "R8", int'(dac_code), 0);
        encmp = 1'b1;
        cyc(TD1 + 1 + DIV * 10);
        chk(dac_code == 8'd10, "R5", int'(dac_code), 10);
        bias = 1'b0;
        cyc(1);
        chk(pwm_hiz == 1'b1 && dac_code == '0, "R8", int'(dac_code), 0);

        // R9: VID invalid at end of hold, then a target below boot.
        vvalid = 1'b0; vid = 8'd12;
        bias = 1'b1;
        cyc(400);
        chk(dac_code == 8'(BOOT), "R9", int'(dac_code), BOOT);
        chk(pgood == 1'b0, "R9", int'(pgood), 0);
        vvalid = 1'b1;
        cyc(200);
        chk(dac_code == 8'd12, "R6", int'(dac_code), 12);
        chk(pgood == 1'b1, "R7", int'(pgood), 1);

        // R3: no-load code in 5-bit mode blocks; 6-bit mode does not.
        drv = 1'b0;
        mode = 2'b11; vid = 8'h1F;
        cyc(2);
        drv = 1'b1;
        cyc(50);
        chk(pwm_hiz == 1'b1, "R3", int'(pwm_hiz), 1);
        mode = 2'b10;
        cyc(2);
        chk(pwm_hiz == 1'b0, "R3", int'(pwm_hiz), 0);
        drv = 1'b0;
        cyc(2);

        // R10: single-stage ramp passes the boot level without pausing.
        mode = 2'b11; vid = 8'h30;
        drv = 1'b1;
        cyc(1);
        chk(pwm_hiz == 1'b0, "R3", int'(pwm_hiz), 0);
        cyc(TD1 + DIV * 25);
        chk(dac_code == 8'd25, "R10", int'(dac_code), 25);
        cyc(300);
        chk(dac_code == 8'h30, "R10", int'(dac_code), 48);
        cyc(2);
        report();
    end

endmodule